// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and a calendar in packed BCD. It holds a seconds field, a minutes field, a 24-hour hours field, a weekday counter, a day-of-month field, a month field and a two-digit year. Every pulse on the one-cycle `tick` input, supplied by an external 1 Hz prescaler, advances the seconds. Carries ripple up the chain. The day-of-month rolls over at the correct length for the current month, and the year field decides whether February has 28 or 29 days.

A host loads any field through a simple write port: enable, field select and a data byte. Fields are read back through a combinational read port addressed by field select. The byte that holds the seconds also carries an oscillator-fail flag in its top bit. The flag is raised by the `osc_fail` input and tells software that the time can no longer be trusted and must be reloaded. The block gives no defined behaviour for illegal values written by the host.

Field select codes: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day-of-month, 5 month, 6 year, 7 unused.

Top module: `bcd_calendar_core`

## Requirements
- R1: Seconds (select 0, bits 6:0) and minutes (select 1, bits 6:0) count 00 to 59 in BCD. A tick taken at 59 sets the field to 00 and advances the next field.
- R2: Hours (select 2, bits 5:0) count 00 to 23 in BCD. A rollover from 23:59:59 sets the time to 00:00:00, advances the day-of-month and advances the weekday.
- R3: The weekday (select 3, bits 2:0) advances 0 to 6 and returns to 0 after 6.
- R4: The day-of-month (select 4, bits 5:0) rolls from 31 to 01 in months 01, 03, 05, 07, 08, 10 and 12. It rolls from 30 to 01 in months 04, 06, 09 and 11. Each rollover advances the month.
- R5: In month 02 the day-of-month rolls after 29 when the BCD year value is a multiple of 4, including 00, and after 28 otherwise.
- R6: The month (select 5, bits 4:0) rolls from 12 to 01 and advances the year. The year (select 6, bits 7:0) rolls from 99 to 00.
- R7: In a cycle with no tick and no write, every field and the flag keep their values.
- R8: A write stores the data into the selected field, and the next read of that field shows it. A write to a field in the same cycle as a tick takes that field's value from the write. Carries still come from the values before the edge.
- R9: The oscillator-fail flag (select 0, bit 7) is 1 after reset. A high `osc_fail` sets it at the next edge. Only a write to select 0 with bit 7 at 0 clears it, and `osc_fail` wins when both happen in the same cycle.
- R10: After reset the fields read 00:00:00, weekday 0, day 01, month 01 and year 00. Bits outside each field read 0 even when written as 1, and select 7 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per second |
| osc_fail | input | 1 | Oscillator failure indication |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 3 | Field select for the write |
| wr_data | input | 8 | Write data (packed BCD) |
| rd_sel | input | 3 | Field select for the read |
| rd_data | output | 8 | Selected field value |

## Verification
Every write, tick and `osc_fail` pulse changes the state at the next rising edge. The read port is combinational, so each result can be read one clock edge after its stimulus. The bench drives its inputs on the falling edge and updates its behavioural model at the rising edge. Between that rising edge and the next falling edge it sweeps all eight selects and compares each against the model. No check therefore depends on the order in which processes run at the edge. Walks of consecutive days and several explicit rollovers exercise the month lengths and leap years at the cycle of the carry.

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       osc_fail,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_sel,
  output logic [7:0] rd_data
);

  logic [6:0] sec, min;
  logic [5:0] hr, dt;
  logic [2:0] wd;
  logic [4:0] mo;
  logic [7:0] yr;
  logic       osf;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    bcd_inc = (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic leap;
  logic [5:0] last_day;
  assign leap = yr[4] ? (yr[3:0] == 4'h2 || yr[3:0] == 4'h6)
                      : (yr[3:0] == 4'h0 || yr[3:0] == 4'h4 || yr[3:0] == 4'h8);

  always_comb begin
    case (mo)
      5'h02:                      last_day = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
      default:                    last_day = 6'h31;
    endcase
  end

  logic sec_wrap, min_wrap, hr_wrap, dt_wrap, mo_wrap;
  assign sec_wrap = tick && sec == 7'h59;
  assign min_wrap = sec_wrap && min == 7'h59;
  assign hr_wrap  = min_wrap && hr == 6'h23;
  assign dt_wrap  = hr_wrap && dt == last_day;
  assign mo_wrap  = dt_wrap && mo == 5'h12;

  logic [7:0] sec_inc, min_inc, hr_inc, dt_inc, mo_inc, yr_inc;
  assign sec_inc = bcd_inc({1'b0, sec});
  assign min_inc = bcd_inc({1'b0, min});
  assign hr_inc  = bcd_inc({2'b0, hr});
  assign dt_inc  = bcd_inc({2'b0, dt});
  assign mo_inc  = bcd_inc({3'b0, mo});
  assign yr_inc  = bcd_inc(yr);

  logic [6:0] we;
  assign we = wr_en ? 7'(8'd1 << wr_sel) : 7'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec <= '0; min <= '0; hr <= '0; wd <= '0;
      dt <= 6'h01; mo <= 5'h01; yr <= '0; osf <= 1'b1;
    end else begin
      if (we[0])         sec <= wr_data[6:0];
      else if (tick)     sec <= sec_wrap ? 7'h00 : sec_inc[6:0];
      if (we[1])         min <= wr_data[6:0];
      else if (sec_wrap) min <= min_wrap ? 7'h00 : min_inc[6:0];
      if (we[2])         hr <= wr_data[5:0];
      else if (min_wrap) hr <= hr_wrap ? 6'h00 : hr_inc[5:0];
      if (we[3])         wd <= wr_data[2:0];
      else if (hr_wrap)  wd <= (wd == 3'd6) ? 3'd0 : wd + 3'd1;
      if (we[4])         dt <= wr_data[5:0];
      else if (hr_wrap)  dt <= dt_wrap ? 6'h01 : dt_inc[5:0];
      if (we[5])         mo <= wr_data[4:0];
      else if (dt_wrap)  mo <= mo_wrap ? 5'h01 : mo_inc[4:0];
      if (we[6])         yr <= wr_data;
      else if (mo_wrap)  yr <= (yr == 8'h99) ? 8'h00 : yr_inc;
      if (osc_fail)                osf <= 1'b1;
      else if (we[0] && !wr_data[7]) osf <= 1'b0;
    end
  end

  always_comb begin
    case (rd_sel)
      3'd0:    rd_data = {osf, sec};
      3'd1:    rd_data = {1'b0, min};
      3'd2:    rd_data = {2'b0, hr};
      3'd3:    rd_data = {5'b0, wd};
      3'd4:    rd_data = {2'b0, dt};
      3'd5:    rd_data = {3'b0, mo};
      3'd6:    rd_data = yr;
      default: rd_data = 8'h00;
    endcase
  end

endmodule

module bcd_calendar_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       osc_fail,
  input logic       wr_en,
  input logic [2:0] wr_sel,
  input logic [7:0] wr_data,
  input logic [2:0] rd_sel,
  input logic [7:0] rd_data,
  input logic [6:0] sec,
  input logic [6:0] min,
  input logic [5:0] hr,
  input logic [2:0] wd,
  input logic       osf
);

  a_r1_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !(wr_en && wr_sel == 3'd0) && sec == 7'h59 |=> sec == 7'h00);

  a_r3_wd_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_en && sec == 7'h59 && min == 7'h59 && hr == 6'h23 && wd == 3'd6 |=> wd == 3'd0);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !wr_en && !osc_fail |=> $stable(sec) && $stable(min) && $stable(hr) && $stable(wd) && $stable(osf));

  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == 3'd1 |=> min == $past(wr_data[6:0]));

  a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    osc_fail |=> osf);

  a_r9_flag_clear_src: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osf) |-> $past(wr_en && wr_sel == 3'd0 && !wr_data[7] && !osc_fail));

  a_r10_unused_sel: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel == 3'd7 |-> rd_data == 8'h00);

endmodule

bind bcd_calendar_core bcd_calendar_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .osc_fail(osc_fail), .wr_en(wr_en),
  .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
  .sec(sec), .min(min), .hr(hr), .wd(wd), .osf(osf)
);

// File: tb/bcd_calendar_core_tb_top.sv
`timescale 1ns/100ps
module bcd_calendar_core_tb_top;
  localparam int CLK_PERIOD = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, osc_fail = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_sel = '0, rd_sel = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  int s = 0, m = 0, h = 0, w = 0, d = 1, mo = 1, y = 0;
  bit osf = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_calendar_core dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .osc_fail(osc_fail),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  function automatic logic [7:0] to_bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int from_bcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int days_in(int mon, int yy);
    if (mon == 2) return (yy % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] model_read(int a);
    case (a)
      0: return {osf, to_bcd(s)[6:0]};
      1: return to_bcd(m);
      2: return to_bcd(h);
      3: return 8'(w);
      4: return to_bcd(d);
      5: return to_bcd(mo);
      6: return to_bcd(y);
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_update(bit t, bit of, bit we, logic [2:0] wa, logic [7:0] wdat);
    if (t) begin
      s++;
      if (s == 60) begin
        s = 0; m++;
        if (m == 60) begin
          m = 0; h++;
          if (h == 24) begin
            h = 0; w = (w + 1) % 7; d++;
            if (d > days_in(mo, y)) begin
              d = 1; mo++;
              if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
            end
          end
        end
      end
    end
    if (we) begin
      case (wa)
        3'd0: begin s = from_bcd(wdat & 8'h7F); if (!wdat[7]) osf = 0; end
        3'd1: m  = from_bcd(wdat & 8'h7F);
        3'd2: h  = from_bcd(wdat & 8'h3F);
        3'd3: w  = int'(wdat[2:0]);
        3'd4: d  = from_bcd(wdat & 8'h3F);
        3'd5: mo = from_bcd(wdat & 8'h1F);
        3'd6: y  = from_bcd(wdat);
        default: ;
      endcase
    end
    if (of) osf = 1;
  endtask

  task automatic compare_all(string tag);
    logic [7:0] exp;
    for (int a = 0; a < 8; a++) begin
      rd_sel = 3'(a);
      #1;
      exp = model_read(a);
      vectors++;
      if (rd_data !== exp) begin
        miscompares++;
        $display("FAIL %s sel %0d actual %02h expected %02h", tag, a, rd_data, exp);
      end
    end
  endtask

  task automatic step(bit t, bit of, bit we, logic [2:0] wa, logic [7:0] wdat, string tag);
    @(negedge clk);
    tick = t; osc_fail = of; wr_en = we; wr_sel = wa; wr_data = wdat;
    @(posedge clk);
    model_update(t, of, we, wa, wdat);
    #1;
    compare_all(tag);
  endtask

  task automatic wr(logic [2:0] wa, logic [7:0] wdat, string tag);
    step(0, 0, 1, wa, wdat, tag);
  endtask

  task automatic load(logic [7:0] hh, logic [7:0] mm, logic [7:0] ss, logic [7:0] ww,
                      logic [7:0] dd, logic [7:0] mn, logic [7:0] yy, string tag);
    wr(3'd6, yy, tag); wr(3'd5, mn, tag); wr(3'd4, dd, tag); wr(3'd3, ww, tag);
    wr(3'd2, hh, tag); wr(3'd1, mm, tag); wr(3'd0, ss, tag);
  endtask

  task automatic tk(string tag);
    step(1, 0, 0, 3'd0, 8'h00, tag);
  endtask

  task automatic day_walk(logic [7:0] yy, int ndays, string tag);
    load(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h12, yy, tag);
    for (int i = 0; i < ndays; i++) begin
      wr(3'd2, 8'h23, tag); wr(3'd1, 8'h59, tag); wr(3'd0, 8'h59, tag);
      tk(tag);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    compare_all("R9/R10 reset");

    // R9: clear, set by osc_fail, set wins over clear, write of 1 does not clear
    wr(3'd0, 8'h00, "R9 clear");
    step(0, 1, 0, 3'd0, 8'h00, "R9 set");
    wr(3'd0, 8'h80, "R9 write one keeps");
    step(0, 1, 1, 3'd0, 8'h00, "R9 set beats clear");
    wr(3'd0, 8'h15, "R9 clear again");

    // R10: out-of-field bits dropped
    wr(3'd2, 8'hE3, "R10 hour mask");
    wr(3'd3, 8'hFD, "R10 weekday mask");
    wr(3'd5, 8'hE9, "R10 month mask");
    wr(3'd7, 8'hFF, "R10 unused select");

    // R7: hold
    for (int i = 0; i < 6; i++) step(0, 0, 0, 3'd0, 8'h00, "R7 hold");

    // R1/R2/R3/R6: full rollover at year end
    load(8'h23, 8'h59, 8'h50, 8'h06, 8'h31, 8'h12, 8'h99, "R6 load");
    for (int i = 0; i < 12; i++) tk("R1 R2 R3 R6 rollover");

    // R1: minutes carry under gapped ticks
    load(8'h10, 8'h58, 8'h00, 8'h02, 8'h05, 8'h06, 8'h42, "R1 load");
    for (int i = 0; i < 300; i++) step(i % 3 != 0, 0, 0, 3'd0, 8'h00, "R1 count");

    // R3: weekday cycle
    for (int i = 0; i < 9; i++) begin
      wr(3'd2, 8'h23, "R3"); wr(3'd1, 8'h59, "R3"); wr(3'd0, 8'h59, "R3");
      tk("R3 weekday");
    end

    // R8: write in same cycle as tick
    load(8'h07, 8'h30, 8'h59, 8'h01, 8'h10, 8'h03, 8'h21, "R8 load");
    step(1, 0, 1, 3'd1, 8'h10, "R8 write beats tick on minutes");
    step(1, 0, 1, 3'd0, 8'h42, "R8 write beats tick on seconds");
    wr(3'd0, 8'h59, "R8");
    step(1, 0, 1, 3'd0, 8'h05, "R8 carry from old seconds");

    // R4/R5: month ends
    load(8'h23, 8'h59, 8'h59, 8'h00, 8'h28, 8'h02, 8'h23, "R5 load");
    tk("R5 feb non-leap");
    load(8'h23, 8'h59, 8'h59, 8'h00, 8'h28, 8'h02, 8'h24, "R5 load");
    tk("R5 feb leap 28");
    wr(3'd2, 8'h23, "R5"); wr(3'd1, 8'h59, "R5"); wr(3'd0, 8'h59, "R5");
    tk("R5 feb leap 29");
    load(8'h23, 8'h59, 8'h59, 8'h00, 8'h30, 8'h04, 8'h10, "R4 load");
    tk("R4 april end");

    // R4/R5: day walks across leap and non-leap Februaries
    day_walk(8'h99, 450, "R4 R5 walk from 99");
    day_walk(8'h15, 430, "R4 R5 walk from 15");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule